// File: doc/BRIEF.md
# Burst-Limited FIFO DMA Requester

This block raises the DMA request line that moves bytes between host memory and a 16-entry parallel port FIFO. Software arms it by setting the DMA enable bit and clearing the service mask bit. From then on, the request follows the FIFO. When the host reads from the port, the block asks for transfers while the FIFO holds bytes. When the host writes to the port, it asks while the FIFO has free entries. Each byte moves during one acknowledge cycle from the host, and that cycle alone selects the FIFO, so no address decode is involved.

Two limits keep the request in check. A run of consecutive acknowledged transfers is capped at 32 so that the host can still schedule memory refresh. After a capped run, the request stays low for a short rest window before it may rise again. When the host signals terminal count on an acknowledged byte, the block drops the request and emits a one-cycle strobe. That strobe sets the service mask and so stops DMA until software clears the mask.

Top module: `fifo_dma_req`

## Requirements
- R1: `dmaReq` is high in a cycle only if, in the previous cycle, `dmaEnable` was 1, `svcMask` was 0 and `setMask` was 0.
- R2: `dirRead` = 1 selects the read direction, in which the block requests while `fifoLevel` > 0. `dirRead` = 0 selects the write direction, in which it requests while `fifoLevel` < 16. If every gating condition holds in a cycle, `dmaReq` is high in the next cycle.
- R3: A byte counts as acknowledged in any cycle where `dmaReq` and `dmaAck` are both high. `dmaReq` is low in the cycle after any cycle in which the FIFO is at its boundary for the direction, or would reach that boundary through that cycle's acknowledged byte. In the read direction this means level 0, or level 1 with an acknowledged byte. In the write direction it means level 16, or level 15 with an acknowledged byte.
- R4: An acknowledged byte with `tcIn` = 1 makes `setMask` high for exactly the next cycle, and `dmaReq` is low in that cycle.
- R5: A continuous high period of `dmaReq` contains at most 32 acknowledged bytes. After the 32nd, `dmaReq` is low in the next cycle.
- R6: After a run is capped at 32, `dmaReq` stays low for exactly 2 cycles. It is high in the third cycle if the gating conditions held in the second.
- R7: The burst count restarts whenever `dmaReq` drops for any reason. A run that follows a shorter, interrupted run may again reach the full 32 bytes.
- R8: While `rstN` is 0, `dmaReq` and `setMask` are 0 whatever the other inputs are, and the burst count and the rest window are cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| dmaEnable | input | 1 | DMA enable bit from the control register |
| svcMask | input | 1 | Service mask bit; 1 blocks requests |
| dirRead | input | 1 | Transfer direction: 1 read (FIFO to host), 0 write (host to FIFO) |
| fifoLevel | input | 5 | Current FIFO occupancy, 0 to 16 |
| dmaAck | input | 1 | Host acknowledge; one byte moves in each acknowledged cycle |
| tcIn | input | 1 | Terminal count, valid together with `dmaAck` |
| dmaReq | output | 1 | DMA request to the host |
| setMask | output | 1 | One-cycle strobe that sets the service mask |

## Verification
The assertions assume that `dmaAck` arrives only while `dmaReq` is high, that `tcIn` is raised only with `dmaAck`, and that `fifoLevel` moves by at most one entry per acknowledged byte. The stimulus holds to these assumptions by drawing the acknowledge only in cycles where the expected request is high. It gates terminal count with that acknowledge. It moves the FIFO level from a single model in which the far side of the FIFO adds or removes at most one entry per cycle. The transfer direction changes only after the enable has been low for several cycles, so no byte is acknowledged across a direction change.

// File: rtl/fifo_dma_pkg.sv
package fifo_dma_pkg;

  // Strobes from the control path to the counting datapath.
  typedef struct packed {
    logic burstInc;   // one more acknowledged byte in the current run
    logic burstClr;   // request falls: restart the run count
    logic restLoad;   // run capped: open the rest window
  } dmaStrobes_t;

endpackage

// File: rtl/fifo_dma_dp.sv
module fifo_dma_dp
  import fifo_dma_pkg::*;
#(
  parameter int DEPTH    = 16,
  parameter int MAXBURST = 32,
  parameter int REST     = 2,
  localparam int LVLW    = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rstN,
  input  dmaStrobes_t     strobes,
  input  logic            dirRead,
  input  logic [LVLW-1:0] fifoLevel,
  input  logic            ackNow,
  output logic            burstLast,
  output logic            resting,
  output logic            fifoStop
);

  localparam int BCW = $clog2(MAXBURST + 1);

  // Run length counter: acknowledged bytes in the current request period.
  logic [BCW-1:0] burstCnt;

  always_ff @(posedge clk) begin
    if (!rstN)                 burstCnt <= '0;
    else if (strobes.burstClr) burstCnt <= '0;
    else if (strobes.burstInc) burstCnt <= burstCnt + 1'b1;
  end

  assign burstLast = (burstCnt == BCW'(MAXBURST - 1));

  // Rest window after a capped run. The cycle in which the request register
  // falls already counts as one rest cycle, so only REST-1 more need a counter.
  generate
    if (REST > 1) begin : g_restCnt
      localparam int RCW = $clog2(REST);
      logic [RCW-1:0] restCnt;
      always_ff @(posedge clk) begin
        if (!rstN)                 restCnt <= '0;
        else if (strobes.restLoad) restCnt <= RCW'(REST - 1);
        else if (restCnt != '0)    restCnt <= restCnt - 1'b1;
      end
      assign resting = (restCnt != '0);
    end else begin : g_noRest
      assign resting = 1'b0;
    end
  endgenerate

  // FIFO boundary, including the byte that moves in this cycle.
  always_comb begin
    if (dirRead)
      fifoStop = (fifoLevel == '0) || (ackNow && fifoLevel == LVLW'(1));
    else
      fifoStop = (fifoLevel == LVLW'(DEPTH)) ||
                 (ackNow && fifoLevel == LVLW'(DEPTH - 1));
  end

endmodule

// File: rtl/fifo_dma_ctl.sv
module fifo_dma_ctl
  import fifo_dma_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        dmaEnable,
  input  logic        svcMask,
  input  logic        dmaAck,
  input  logic        tcIn,
  input  logic        burstLast,
  input  logic        resting,
  input  logic        fifoStop,
  output logic        ackNow,
  output dmaStrobes_t strobes,
  output logic        dmaReq,
  output logic        setMask
);

  logic tcHit;
  logic capHit;
  logic reqNext;

  assign ackNow = dmaReq && dmaAck;
  assign tcHit  = ackNow && tcIn;
  assign capHit = ackNow && burstLast;

  // The pending mask strobe blocks the request until the mask bit itself is set.
  assign reqNext = dmaEnable && !svcMask && !setMask && !resting &&
                   !fifoStop && !capHit && !tcHit;

  always_comb begin
    strobes.burstInc = reqNext && ackNow;
    strobes.burstClr = !reqNext;
    strobes.restLoad = capHit;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dmaReq  <= 1'b0;
      setMask <= 1'b0;
    end else begin
      dmaReq  <= reqNext;
      setMask <= tcHit;
    end
  end

endmodule

// File: rtl/fifo_dma_req.sv
module fifo_dma_req
  import fifo_dma_pkg::*;
#(
  parameter int DEPTH    = 16,
  parameter int MAXBURST = 32,
  parameter int REST     = 2,
  localparam int LVLW    = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            dmaEnable,
  input  logic            svcMask,
  input  logic            dirRead,
  input  logic [LVLW-1:0] fifoLevel,
  input  logic            dmaAck,
  input  logic            tcIn,
  output logic            dmaReq,
  output logic            setMask
);

  dmaStrobes_t strobes;
  logic        ackNow;
  logic        burstLast;
  logic        resting;
  logic        fifoStop;

  fifo_dma_ctl u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .dmaEnable (dmaEnable),
    .svcMask   (svcMask),
    .dmaAck    (dmaAck),
    .tcIn      (tcIn),
    .burstLast (burstLast),
    .resting   (resting),
    .fifoStop  (fifoStop),
    .ackNow    (ackNow),
    .strobes   (strobes),
    .dmaReq    (dmaReq),
    .setMask   (setMask)
  );

  fifo_dma_dp #(
    .DEPTH    (DEPTH),
    .MAXBURST (MAXBURST),
    .REST     (REST)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .dirRead   (dirRead),
    .fifoLevel (fifoLevel),
    .ackNow    (ackNow),
    .burstLast (burstLast),
    .resting   (resting),
    .fifoStop  (fifoStop)
  );

endmodule

// File: rtl/fifo_dma_chk.sv
module fifo_dma_chk #(
  parameter int DEPTH    = 16,
  parameter int MAXBURST = 32,
  parameter int REST     = 2,
  localparam int LVLW    = $clog2(DEPTH + 1)
) (
  input logic            clk,
  input logic            rstN,
  input logic            dmaEnable,
  input logic            svcMask,
  input logic            dirRead,
  input logic [LVLW-1:0] fifoLevel,
  input logic            dmaAck,
  input logic            tcIn,
  input logic            dmaReq,
  input logic            setMask
);

  localparam int CW = $clog2(MAXBURST + 1) + 1;
  localparam int GW = $clog2(REST + 1) + 1;

  // Acknowledged bytes seen in the current high period of the request.
  logic [CW-1:0] runAcks;
  // Cycles of enforced low request still owed after a capped run.
  logic [GW-1:0] restGuard;

  always_ff @(posedge clk) begin
    if (!rstN)        runAcks <= '0;
    else if (!dmaReq) runAcks <= '0;
    else if (dmaAck)  runAcks <= runAcks + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      restGuard <= '0;
    else if (dmaReq && dmaAck && runAcks == CW'(MAXBURST - 1))
      restGuard <= GW'(REST);
    else if (restGuard != '0)
      restGuard <= restGuard - 1'b1;
  end

  p_req_gate_r1: assert property (@(posedge clk) disable iff (!rstN)
    (!dmaEnable || svcMask || setMask) |=> !dmaReq);

  p_read_empty_r2: assert property (@(posedge clk) disable iff (!rstN)
    (dirRead && fifoLevel == '0) |=> !dmaReq);

  p_write_full_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!dirRead && fifoLevel == LVLW'(DEPTH)) |=> !dmaReq);

  p_read_drain_r3: assert property (@(posedge clk) disable iff (!rstN)
    (dmaReq && dmaAck && dirRead && fifoLevel == LVLW'(1)) |=> !dmaReq);

  p_write_fill_r3: assert property (@(posedge clk) disable iff (!rstN)
    (dmaReq && dmaAck && !dirRead && fifoLevel == LVLW'(DEPTH - 1)) |=> !dmaReq);

  p_tc_stop_r4: assert property (@(posedge clk) disable iff (!rstN)
    (dmaReq && dmaAck && tcIn) |=> (setMask && !dmaReq));

  p_strobe_single_r4: assert property (@(posedge clk) disable iff (!rstN)
    setMask |=> !setMask);

  p_burst_cap_r5: assert property (@(posedge clk) disable iff (!rstN)
    dmaReq |-> (runAcks < CW'(MAXBURST)));

  p_rest_gap_r6: assert property (@(posedge clk) disable iff (!rstN)
    (restGuard != '0) |-> !dmaReq);

endmodule

bind fifo_dma_req fifo_dma_chk #(
  .DEPTH    (DEPTH),
  .MAXBURST (MAXBURST),
  .REST     (REST)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .dmaEnable (dmaEnable),
  .svcMask   (svcMask),
  .dirRead   (dirRead),
  .fifoLevel (fifoLevel),
  .dmaAck    (dmaAck),
  .tcIn      (tcIn),
  .dmaReq    (dmaReq),
  .setMask   (setMask)
);

// File: tb/fifo_dma_req_tb.sv
`timescale 1ns/1ps
module fifo_dma_req_tb;

  localparam int DEPTH = 16;
  localparam int MAXB  = 32;
  localparam int REST  = 2;
  localparam int LVLW  = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic dmaEnable = 1'b0;
  logic svcMask = 1'b0;
  logic dirRead = 1'b0;
  logic [LVLW-1:0] fifoLevel = '0;
  logic dmaAck = 1'b0;
  logic tcIn = 1'b0;
  logic dmaReq;
  logic setMask;

  always #2.5 clk = ~clk;

  fifo_dma_req #(.DEPTH(DEPTH), .MAXBURST(MAXB), .REST(REST)) u_dut (
    .clk(clk), .rstN(rstN), .dmaEnable(dmaEnable), .svcMask(svcMask),
    .dirRead(dirRead), .fifoLevel(fifoLevel), .dmaAck(dmaAck), .tcIn(tcIn),
    .dmaReq(dmaReq), .setMask(setMask)
  );

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  // Reference state, built from the requirements.
  bit    eReq = 0, eSet = 0, mask = 0, phaseDir = 0;
  int    run = 0, restLeft = 0, level = 8;
  string tag = "R8";

  // Run observation at the ports.
  int obsRun = 0;
  bit prevReq = 0, lastShort = 0, sawCap = 0, sawR7 = 0;

  task automatic chk(string rq, logic act, logic exp, string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0b expected %0b at %0t", rq, what, act, exp, $time);
    end
  endtask

  function automatic bit calcStop(bit dir, int lvl, bit ack);
    if (dir) return (lvl == 0) || (ack && lvl == 1);       // R3 read side
    else     return (lvl == DEPTH) || (ack && lvl == DEPTH - 1); // R3 write side
  endfunction

  function automatic bit calcReq(bit en, bit msk, bit pend, int rl, bit stop,
                                 bit cap, bit tcH);
    return en && !msk && !pend && (rl == 0) && !stop && !cap && !tcH;
  endfunction

  function automatic string pickTag(bit tcH, bit cap, int rl, bit stop, bit en, bit msk);
    if (tcH)             return "R4";
    if (cap)             return "R5";
    if (rl != 0)         return "R6";
    if (stop)            return "R3";
    if (!en || msk)      return "R1";
    return "R2";
  endfunction

  task automatic cycle(bit en, int ackP, int tcP, int sideP, bit swClr);
    bit ack, tc, side, stop, cap, nReq;
    @(negedge clk);
    chk(tag, dmaReq, eReq, "dmaReq");
    chk(tag, setMask, eSet, "setMask");
    ack  = eReq && ($urandom_range(99) < ackP);
    tc   = ack && ($urandom_range(99) < tcP);
    side = ($urandom_range(99) < sideP);
    // observed run lengths (R5, R7)
    if (dmaReq && ack) obsRun++;
    if (!dmaReq && prevReq && obsRun > 0) begin
      if (obsRun == MAXB) begin
        sawCap = 1;
        if (lastShort) sawR7 = 1;
        lastShort = 0;
      end else lastShort = 1;
      obsRun = 0;
    end
    prevReq = dmaReq;
    dmaEnable = en;
    svcMask   = mask;
    dirRead   = phaseDir;
    fifoLevel = LVLW'(level);
    dmaAck    = ack;
    tcIn      = tc;
    stop = calcStop(phaseDir, level, ack);
    cap  = ack && (run == MAXB - 1);
    nReq = calcReq(en, mask, eSet, restLeft, stop, cap, tc);
    tag  = pickTag(tc, cap, restLeft, stop, en, mask || eSet);
    run      = nReq ? run + int'(ack) : 0;
    restLeft = cap ? REST - 1 : (restLeft > 0 ? restLeft - 1 : 0);
    mask     = eSet ? 1'b1 : (swClr ? 1'b0 : mask);
    eSet     = tc;
    eReq     = nReq;
    if (phaseDir) level = level - int'(ack) + ((side && level - int'(ack) < DEPTH) ? 1 : 0);
    else          level = level + int'(ack) - ((side && level + int'(ack) > 0) ? 1 : 0);
  endtask

  task automatic startPhase(bit newDir);
    for (int i = 0; i < 3; i++) cycle(1'b0, 100, 0, 50, 1'b1);
    phaseDir = newDir;
    mask = 0;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    // R8: reset holds outputs low even with an armed, eligible setup
    dmaEnable = 1'b1;
    fifoLevel = LVLW'(8);
    repeat (3) @(negedge clk);
    chk("R8", dmaReq, 1'b0, "dmaReq in reset");
    chk("R8", setMask, 1'b0, "setMask in reset");
    dmaEnable = 1'b0;
    rstN = 1'b1;

    // R5/R6: write direction, constant acknowledge, far side drains each cycle
    startPhase(1'b0);
    for (int i = 0; i < 120; i++) cycle(1'b1, 100, 0, 100, 1'b0);
    // R7: interrupted run followed by a full one
    startPhase(1'b0);
    for (int i = 0; i < 10; i++) cycle(1'b1, 100, 0, 100, 1'b0);
    cycle(1'b0, 100, 0, 100, 1'b0);
    for (int i = 0; i < 60; i++) cycle(1'b1, 100, 0, 100, 1'b0);
    // R3: read direction, nothing refills, FIFO drains to empty
    startPhase(1'b1);
    for (int i = 0; i < 30; i++) cycle(1'b1, 100, 0, 0, 1'b0);
    // R4: terminal count on the first acknowledged byte
    startPhase(1'b0);
    for (int i = 0; i < 6; i++) cycle(1'b1, 100, 100, 50, 1'b0);
    for (int i = 0; i < 6; i++) cycle(1'b1, 100, 0, 50, 1'b1);

    // Constrained random phases
    for (int p = 0; p < 40; p++) begin
      int ackP, tcP, sideP, dropP;
      startPhase(bit'($urandom_range(1)));
      ackP  = ($urandom_range(2) == 0) ? 100 : 30 + $urandom_range(60);
      tcP   = ($urandom_range(2) == 0) ? 3 : 0;
      sideP = 40 + $urandom_range(60);
      dropP = $urandom_range(3);
      for (int i = 0; i < 300; i++)
        cycle(!($urandom_range(99) < dropP), ackP, tcP, sideP,
              $urandom_range(99) < 20);
    end

    chk("R5", sawCap, 1'b1, "run of 32 observed");
    chk("R7", sawR7, 1'b1, "full run after interrupted run");
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog (all requirements): actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule